// File: doc/BRIEF.md
# SCSI controller command register decoder

This block is the byte-wide register front end of a SCSI protocol controller. A host writes opcodes to a command register. Each legal opcode loads a fixed pattern into the read-side interrupt-cause, sequence-step, status and flags registers. The block drives one level-sensitive interrupt request line, and bit 7 of the status register always follows that line. A host bus carries an address, write data, registered read data and separate read and write strobes. The register index is the address shifted right by `ADDR_SHIFT`.

A small command FIFO accepts byte writes and refuses any byte that would fill its last slot, recording an overrun instead. A two-byte transfer count is written to a staging copy and becomes live only when a command with the DMA flag arrives. A bus-reset opcode produces a one-cycle pulse on `bus_reset_pulse`. Bit 6 of configuration register 1 can stop that opcode from raising the interrupt. The SCSI bus signalling itself and any attached targets are handled elsewhere.

Register indices: 0 count low, 1 count mid, 2 FIFO, 3 command, 4 status, 5 interrupt cause, 6 sequence step, 7 flags, 8 configuration 1, 9 count high. Status bits: 7 interrupt, 6 gross error, 5 parity error, 4 terminal count, 2:0 bus phase. Flags bits: 7 illegal command (sticky), 6 FIFO overrun (sticky), 4:0 FIFO byte count. Interrupt cause values: 0x80 reset detected, 0x20 disconnect, 0x08 function complete. A command byte holds the opcode in bits 6:0 and the DMA flag in bit 7.

Top module: `scsi_cmd_regblk`

## Requirements
- R1: After `rst_n` is released, status, interrupt cause, sequence step, flags and both live count bytes read 0x00, configuration 1 reads 0x07, count high reads 0x04, and `irq` is 0.
- R2: Only a command write can raise the interrupt, and raising it sets status bit 7 and `irq` together. A second raising command while the interrupt is already set leaves `irq` at 1, and its cause value replaces the earlier one.
- R3: Opcode 0x01 empties the FIFO, sets the cause to 0x08, clears the sequence step and the whole flags register, and raises the interrupt.
- R4: Opcode 0x03 sets the cause to 0x80 and drives `bus_reset_pulse` high for exactly the one cycle after the write. It raises the interrupt only when configuration 1 bit 6 is 0.
- R5: Opcode 0x11 sets the cause to 0x08, sets the status phase field (bits 2:0) to 3'b111, loads sequence step 2 and raises the interrupt.
- R6: Opcode 0x12 sets the cause to 0x20, clears the sequence step and raises the interrupt.
- R7: Opcode 0x44 clears the cause register and does not change `irq`.
- R8: Opcode 0x02 returns every register, the FIFO and `irq` to the values of R1.
- R9: A legal command with bit 7 set copies the staged count low and mid bytes to the live registers. Writes to count low and mid alone do not change the live values.
- R10: A DMA-flagged command sets status bit 4 when the staged count is zero and clears it otherwise. A FIFO write clears status bit 4.
- R11: A read of the interrupt cause returns its value from before the read. It then clears the cause, the sequence step and status bits 6 and 5, and lowers `irq`.
- R12: An opcode other than 0x00, 0x01, 0x02, 0x03, 0x11, 0x12 and 0x44 changes no register except that it sets flags bit 7, which stays set until opcode 0x01 or 0x02.
- R13: A FIFO write made while FIFO_DEPTH-1 bytes are held is dropped. It sets flags bit 6 and status bit 6, and the count stays at FIFO_DEPTH-1.
- R14: FIFO reads return the bytes in the order they were written. A read of an empty FIFO returns 0x00. The register index ignores the low `ADDR_SHIFT` address bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Host address; index = addr >> ADDR_SHIFT |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt request |
| bus_reset_pulse | output | 1 | One-cycle pulse for each bus-reset command |

## Verification
Each opcode is run from a freshly reset register file. This shows which cause, status, sequence and flags pattern belongs to which opcode, and keeps an earlier command from leaving values behind. The bus-reset opcode runs once with configuration bit 6 clear and once with it set, which separates loading the cause from raising the interrupt. Directed sequences chain commands to show that cause values are replaced while the interrupt stays raised, and that a cause read returns the old value. Further sequences stage counts, including a zero count, to tell a live reload apart from a staging write. The FIFO is filled to its limit and then read back, which exposes dropped bytes, the ordering of accepted bytes and the sticky overrun flag.

// File: rtl/scsi_cmd_pkg.sv
package scsi_cmd_pkg;

   localparam int IDX_W = 4;

   localparam logic [IDX_W-1:0] IDX_CNT_LO  = 4'd0;
   localparam logic [IDX_W-1:0] IDX_CNT_MID = 4'd1;
   localparam logic [IDX_W-1:0] IDX_FIFO    = 4'd2;
   localparam logic [IDX_W-1:0] IDX_CMD     = 4'd3;
   localparam logic [IDX_W-1:0] IDX_STATUS  = 4'd4;
   localparam logic [IDX_W-1:0] IDX_CAUSE   = 4'd5;
   localparam logic [IDX_W-1:0] IDX_SEQ     = 4'd6;
   localparam logic [IDX_W-1:0] IDX_FLAGS   = 4'd7;
   localparam logic [IDX_W-1:0] IDX_CFG1    = 4'd8;
   localparam logic [IDX_W-1:0] IDX_CNT_HI  = 4'd9;

   localparam logic [6:0] OP_NOP     = 7'h00;
   localparam logic [6:0] OP_FLUSH   = 7'h01;
   localparam logic [6:0] OP_CHIPRST = 7'h02;
   localparam logic [6:0] OP_BUSRST  = 7'h03;
   localparam logic [6:0] OP_ICCS    = 7'h11;
   localparam logic [6:0] OP_MSGACC  = 7'h12;
   localparam logic [6:0] OP_ENSEL   = 7'h44;

   localparam logic [7:0] CAUSE_RST   = 8'h80;
   localparam logic [7:0] CAUSE_DISC  = 8'h20;
   localparam logic [7:0] CAUSE_FDONE = 8'h08;

   localparam logic [2:0] PHASE_MSGIN = 3'b111;
   localparam logic [2:0] SEQ_ICCS    = 3'd2;
   localparam logic [7:0] CFG1_RESET  = 8'h07;
   localparam int         CFG1_NO_RST_IRQ_BIT = 6;
   localparam int         CMD_DMA_BIT = 7;

   typedef struct packed {
      logic       legal;
      logic       do_flush;
      logic       do_chip_rst;
      logic       do_bus_rst;
      logic       load_cause;
      logic [7:0] cause_val;
      logic       raise;
      logic       clr_seq;
      logic       set_seq;
      logic       clr_flags;
      logic       set_msgin;
   } cmd_action_t;

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
   import scsi_cmd_pkg::*;
(
   input  logic [6:0]  opcode,
   input  logic        no_rst_irq,
   output cmd_action_t act
);

   always_comb begin
      act       = '0;
      act.legal = 1'b1;
      case (opcode)
         OP_NOP: begin
         end
         OP_FLUSH: begin
            act.do_flush   = 1'b1;
            act.load_cause = 1'b1;
            act.cause_val  = CAUSE_FDONE;
            act.clr_seq    = 1'b1;
            act.clr_flags  = 1'b1;
            act.raise      = 1'b1;
         end
         OP_CHIPRST: begin
            act.do_chip_rst = 1'b1;
         end
         OP_BUSRST: begin
            act.do_bus_rst = 1'b1;
            act.load_cause = 1'b1;
            act.cause_val  = CAUSE_RST;
            act.raise      = !no_rst_irq;
         end
         OP_ICCS: begin
            act.load_cause = 1'b1;
            act.cause_val  = CAUSE_FDONE;
            act.set_msgin  = 1'b1;
            act.set_seq    = 1'b1;
            act.raise      = 1'b1;
         end
         OP_MSGACC: begin
            act.load_cause = 1'b1;
            act.cause_val  = CAUSE_DISC;
            act.clr_seq    = 1'b1;
            act.raise      = 1'b1;
         end
         OP_ENSEL: begin
            act.load_cause = 1'b1;
            act.cause_val  = 8'h00;
         end
         default: begin
            act.legal = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/scsi_cmd_fifo.sv
module scsi_cmd_fifo #(
   parameter int DEPTH = 16,
   parameter int CNT_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [7:0]       push_data,
   input  logic             pop,
   output logic [7:0]       pop_data,
   output logic [CNT_W-1:0] count,
   output logic             drop
);

   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEPTH - 1);

   logic [7:0]       mem [DEPTH];
   logic [CNT_W-1:0] wr_ptr;
   logic [CNT_W-1:0] rd_ptr;
   logic             push_ok;
   logic             pop_ok;

   assign push_ok = push && (count != LIMIT);
   assign pop_ok  = pop && (count != '0);
   assign drop    = push && (count == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok && !clr) mem[wr_ptr] <= push_data;
   end

   assign pop_data = (count != '0) ? mem[rd_ptr] : 8'h00;

endmodule

// File: rtl/scsi_xfer_count.sv
module scsi_xfer_count #(
   parameter int NBYTES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic [NBYTES-1:0]   wr_sel,
   input  logic [7:0]          wdata,
   input  logic                reload,
   output logic [NBYTES*8-1:0] live,
   output logic                staged_zero
);

   logic [NBYTES*8-1:0] staged;

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            staged[b*8 +: 8] <= 8'h00;
            live[b*8 +: 8]   <= 8'h00;
         end else if (clr) begin
            staged[b*8 +: 8] <= 8'h00;
            live[b*8 +: 8]   <= 8'h00;
         end else begin
            if (wr_sel[b]) staged[b*8 +: 8] <= wdata;
            if (reload)    live[b*8 +: 8]   <= staged[b*8 +: 8];
         end
      end
   end

   assign staged_zero = (staged == '0);

endmodule

// File: rtl/scsi_cmd_regblk.sv
module scsi_cmd_regblk
   import scsi_cmd_pkg::*;
#(
   parameter int         ADDR_W     = 8,
   parameter int         ADDR_SHIFT = 2,
   parameter int         FIFO_DEPTH = 16,
   parameter logic [7:0] REV_ID     = 8'h04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              irq,
   output logic              bus_reset_pulse
);

   localparam int CNT_W  = $clog2(FIFO_DEPTH);
   localparam int NBYTES = 2;

   initial begin : p_param_check
      assert (FIFO_DEPTH >= 4 && FIFO_DEPTH <= 32 && (FIFO_DEPTH & (FIFO_DEPTH - 1)) == 0)
         else $fatal(1, "FIFO_DEPTH must be a power of two in 4..32");
      assert (ADDR_W >= ADDR_SHIFT + IDX_W)
         else $fatal(1, "ADDR_W too small for ADDR_SHIFT");
   end

   logic [IDX_W-1:0] idx;
   logic             unused_addr;

   if (ADDR_SHIFT == 0) begin : g_idx_direct
      assign idx = addr[IDX_W-1:0];
   end else begin : g_idx_shifted
      assign idx = addr[ADDR_SHIFT +: IDX_W];
   end
   assign unused_addr = ^addr;

   // register state
   logic       int_q, ge_q, tc_q;
   logic [2:0] phase_q;
   logic [7:0] cause_q;
   logic [2:0] seq_q;
   logic       illegal_q, ovr_q;
   logic [7:0] cfg1_q;
   logic [7:0] cmd_q;
   logic       bus_rst_q;
   logic [7:0] rdata_q;

   // strobes
   logic cmd_wr, fifo_wr, fifo_rd, cfg1_wr, cause_rd;
   assign cmd_wr   = wr_en && (idx == IDX_CMD);
   assign fifo_wr  = wr_en && (idx == IDX_FIFO);
   assign cfg1_wr  = wr_en && (idx == IDX_CFG1);
   assign fifo_rd  = rd_en && (idx == IDX_FIFO);
   assign cause_rd = rd_en && (idx == IDX_CAUSE);

   cmd_action_t act;

   scsi_cmd_decode u_decode (
      .opcode     (wdata[6:0]),
      .no_rst_irq (cfg1_q[CFG1_NO_RST_IRQ_BIT]),
      .act        (act)
   );

   logic legal_cmd, soft_rst, flush, reload;
   assign legal_cmd = cmd_wr && act.legal;
   assign soft_rst  = legal_cmd && act.do_chip_rst;
   assign flush     = legal_cmd && act.do_flush;
   assign reload    = legal_cmd && wdata[CMD_DMA_BIT] && !soft_rst;

   logic [7:0]       fifo_out;
   logic [CNT_W-1:0] fifo_count;
   logic             fifo_drop;

   scsi_cmd_fifo #(
      .DEPTH (FIFO_DEPTH),
      .CNT_W (CNT_W)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (soft_rst || flush),
      .push      (fifo_wr),
      .push_data (wdata),
      .pop       (fifo_rd),
      .pop_data  (fifo_out),
      .count     (fifo_count),
      .drop      (fifo_drop)
   );

   logic [NBYTES*8-1:0] live_cnt;
   logic                staged_zero;

   scsi_xfer_count #(
      .NBYTES (NBYTES)
   ) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (soft_rst),
      .wr_sel      ({wr_en && (idx == IDX_CNT_MID), wr_en && (idx == IDX_CNT_LO)}),
      .wdata       (wdata),
      .reload      (reload),
      .live        (live_cnt),
      .staged_zero (staged_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_q     <= 1'b0;
         ge_q      <= 1'b0;
         tc_q      <= 1'b0;
         phase_q   <= 3'd0;
         cause_q   <= 8'h00;
         seq_q     <= 3'd0;
         illegal_q <= 1'b0;
         ovr_q     <= 1'b0;
         cfg1_q    <= CFG1_RESET;
         cmd_q     <= 8'h00;
         bus_rst_q <= 1'b0;
      end else if (soft_rst) begin
         int_q     <= 1'b0;
         ge_q      <= 1'b0;
         tc_q      <= 1'b0;
         phase_q   <= 3'd0;
         cause_q   <= 8'h00;
         seq_q     <= 3'd0;
         illegal_q <= 1'b0;
         ovr_q     <= 1'b0;
         cfg1_q    <= CFG1_RESET;
         cmd_q     <= 8'h00;
         bus_rst_q <= 1'b0;
      end else begin
         if (cause_rd) begin
            cause_q <= 8'h00;
            seq_q   <= 3'd0;
            ge_q    <= 1'b0;
            int_q   <= 1'b0;
         end
         if (fifo_wr) tc_q <= 1'b0;
         if (fifo_drop) begin
            ge_q  <= 1'b1;
            ovr_q <= 1'b1;
         end
         if (cfg1_wr) cfg1_q <= wdata;
         if (cmd_wr) begin
            if (!act.legal) begin
               illegal_q <= 1'b1;
            end else begin
               cmd_q <= wdata;
               if (wdata[CMD_DMA_BIT]) tc_q    <= staged_zero;
               if (act.load_cause)     cause_q <= act.cause_val;
               if (act.raise)          int_q   <= 1'b1;
               if (act.clr_seq)        seq_q   <= 3'd0;
               if (act.set_seq)        seq_q   <= SEQ_ICCS;
               if (act.set_msgin)      phase_q <= PHASE_MSGIN;
               if (act.clr_flags) begin
                  illegal_q <= 1'b0;
                  ovr_q     <= 1'b0;
               end
            end
         end
         bus_rst_q <= legal_cmd && act.do_bus_rst;
      end
   end

   logic [7:0] status_val, flags_val, rd_val;
   assign status_val = {int_q, ge_q, 1'b0, tc_q, 1'b0, phase_q};
   assign flags_val  = {illegal_q, ovr_q, 1'b0, 5'(fifo_count)};

   always_comb begin
      case (idx)
         IDX_CNT_LO:  rd_val = live_cnt[7:0];
         IDX_CNT_MID: rd_val = live_cnt[15:8];
         IDX_FIFO:    rd_val = fifo_out;
         IDX_CMD:     rd_val = cmd_q;
         IDX_STATUS:  rd_val = status_val;
         IDX_CAUSE:   rd_val = cause_q;
         IDX_SEQ:     rd_val = {5'd0, seq_q};
         IDX_FLAGS:   rd_val = flags_val;
         IDX_CFG1:    rd_val = cfg1_q;
         IDX_CNT_HI:  rd_val = REV_ID;
         default:     rd_val = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_q <= 8'h00;
      else if (rd_en) rdata_q <= rd_val;
   end

   assign rdata           = rdata_q;
   assign irq             = int_q;
   assign bus_reset_pulse = bus_rst_q;

endmodule

// File: rtl/scsi_cmd_regblk_chk.sv
module scsi_cmd_regblk_chk
   import scsi_cmd_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int CNT_W      = $clog2(FIFO_DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic [IDX_W-1:0] idx,
   input logic [7:0]       wdata,
   input logic             irq,
   input logic             bus_reset_pulse,
   input logic [CNT_W-1:0] fifo_count,
   input logic             illegal_q,
   input logic [7:0]       cfg1_q
);

   logic cmd_wr;
   assign cmd_wr = wr_en && (idx == IDX_CMD);

   AST_IRQ_RISE_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(cmd_wr)); // R2

   AST_CAUSE_RD_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && idx == IDX_CAUSE && !cmd_wr) |=> !irq); // R11

   AST_BUSRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wdata[6:0] == OP_BUSRST) |=> bus_reset_pulse); // R4

   AST_BUSRST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_wr && wdata[6:0] == OP_BUSRST) |=> !bus_reset_pulse); // R4

   AST_BUSRST_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wdata[6:0] == OP_BUSRST && cfg1_q[6] && !irq) |=> !irq); // R4

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == IDX_FIFO && fifo_count == CNT_W'(FIFO_DEPTH - 1))
      |=> $stable(fifo_count)); // R13

   AST_CHIP_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wdata[6:0] == OP_CHIPRST)
      |=> (cfg1_q == CFG1_RESET && !irq && fifo_count == '0)); // R8

   AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal_q && !(cmd_wr && (wdata[6:0] == OP_FLUSH || wdata[6:0] == OP_CHIPRST)))
      |=> illegal_q); // R12

endmodule

bind scsi_cmd_regblk scsi_cmd_regblk_chk #(
   .FIFO_DEPTH (FIFO_DEPTH),
   .CNT_W      (CNT_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .wr_en           (wr_en),
   .rd_en           (rd_en),
   .idx             (idx),
   .wdata           (wdata),
   .irq             (irq),
   .bus_reset_pulse (bus_reset_pulse),
   .fifo_count      (fifo_count),
   .illegal_q       (illegal_q),
   .cfg1_q          (cfg1_q)
);

// File: tb/scsi_cmd_regblk_tb.sv
module scsi_cmd_regblk_tb;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 8;
   localparam int SHIFT      = 2;
   localparam int DEPTH      = 16;

   localparam logic [3:0] I_LO = 0, I_MID = 1, I_FIFO = 2, I_CMD = 3, I_STAT = 4,
                          I_CAUSE = 5, I_SEQ = 6, I_FLAGS = 7, I_CFG1 = 8, I_HI = 9;

   // {cfg1, opcode, cause, status, seq, flags}
   localparam int NVEC = 8;
   localparam logic [47:0] VEC [NVEC] = '{
      48'h07_01_08_80_00_00,
      48'h07_03_80_80_00_00,
      48'h47_03_80_00_00_00,
      48'h07_11_08_87_02_00,
      48'h07_12_20_80_00_00,
      48'h07_44_00_00_00_00,
      48'h07_00_00_00_00_00,
      48'h07_2A_00_00_00_80
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [7:0]        wdata = 8'h00;
   logic [7:0]        rdata;
   logic              irq;
   logic              bus_reset_pulse;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scsi_cmd_regblk #(
      .ADDR_W     (ADDR_W),
      .ADDR_SHIFT (SHIFT),
      .FIFO_DEPTH (DEPTH)
   ) u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .addr            (addr),
      .wr_en           (wr_en),
      .rd_en           (rd_en),
      .wdata           (wdata),
      .rdata           (rdata),
      .irq             (irq),
      .bus_reset_pulse (bus_reset_pulse)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] idx, input logic [7:0] d);
      @(negedge clk);
      addr  = ADDR_W'(idx) << SHIFT;
      wdata = d;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] idx, output logic [7:0] d);
      @(negedge clk);
      addr  = ADDR_W'(idx) << SHIFT;
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   function automatic string req_of(input logic [7:0] op);
      case (op)
         8'h01:   return "R3";
         8'h03:   return "R4";
         8'h11:   return "R5";
         8'h12:   return "R6";
         8'h44:   return "R7";
         8'h00:   return "R2";
         default: return "R12";
      endcase
   endfunction

   initial begin : p_watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : p_main
      logic [7:0] v;
      logic [7:0] b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq", {7'd0, irq}, 8'h00);
      rd(I_STAT, v);  chk("R1 status", v, 8'h00);
      rd(I_SEQ, v);   chk("R1 seq", v, 8'h00);
      rd(I_FLAGS, v); chk("R1 flags", v, 8'h00);
      rd(I_CFG1, v);  chk("R1 cfg1", v, 8'h07);
      rd(I_HI, v);    chk("R1 count high", v, 8'h04);
      rd(I_LO, v);    chk("R1 count low", v, 8'h00);
      rd(I_CAUSE, v); chk("R1 cause", v, 8'h00);

      // opcode table walk
      for (int i = 0; i < NVEC; i++) begin
         logic [7:0] op;
         string      rq;
         op = VEC[i][39:32];
         rq = req_of(op);
         wr(I_CMD, 8'h02);
         wr(I_CFG1, VEC[i][47:40]);
         wr(I_CMD, op);
         chk({rq, " irq/status7 R2"}, {7'd0, irq}, {7'd0, VEC[i][23]});
         rd(I_STAT, v);  chk({rq, " status"}, v, VEC[i][23:16]);
         rd(I_SEQ, v);   chk({rq, " seq"}, v, VEC[i][15:8]);
         rd(I_FLAGS, v); chk({rq, " flags"}, v, VEC[i][7:0]);
         rd(I_CAUSE, v); chk({rq, " cause"}, v, VEC[i][31:24]);
         chk({rq, " irq after cause read R11"}, {7'd0, irq}, 8'h00);
         rd(I_CAUSE, v); chk({rq, " cause cleared R11"}, v, 8'h00);
      end

      // R2: second raise while raised, R11 clears seq
      wr(I_CMD, 8'h02);
      wr(I_CMD, 8'h12);
      wr(I_CMD, 8'h11);
      chk("R2 irq held", {7'd0, irq}, 8'h01);
      rd(I_CAUSE, v); chk("R2 cause replaced", v, 8'h08);
      rd(I_SEQ, v);   chk("R11 seq cleared", v, 8'h00);
      chk("R11 irq low", {7'd0, irq}, 8'h00);

      // R7: enable selection keeps irq
      wr(I_CMD, 8'h12);
      wr(I_CMD, 8'h44);
      chk("R7 irq unchanged", {7'd0, irq}, 8'h01);
      rd(I_CAUSE, v); chk("R7 cause cleared", v, 8'h00);

      // R4 pulse width
      wr(I_CMD, 8'h03);
      chk("R4 pulse high", {7'd0, bus_reset_pulse}, 8'h01);
      @(negedge clk);
      chk("R4 pulse one cycle", {7'd0, bus_reset_pulse}, 8'h00);
      rd(I_CAUSE, v);

      // R9 / R10 transfer count and terminal count
      wr(I_LO, 8'h34);
      wr(I_MID, 8'h12);
      rd(I_LO, v);   chk("R9 live not yet", v, 8'h00);
      wr(I_CMD, 8'h80);
      rd(I_LO, v);   chk("R9 live low", v, 8'h34);
      rd(I_MID, v);  chk("R9 live mid", v, 8'h12);
      rd(I_STAT, v); chk("R10 tc clear nonzero", v & 8'h10, 8'h00);
      wr(I_LO, 8'h00);
      wr(I_MID, 8'h00);
      wr(I_CMD, 8'h80);
      rd(I_STAT, v); chk("R10 tc set on zero", v & 8'h10, 8'h10);
      rd(I_MID, v);  chk("R9 live mid zero", v, 8'h00);
      wr(I_FIFO, 8'hA5);
      rd(I_STAT, v); chk("R10 tc cleared by fifo write", v & 8'h10, 8'h00);

      // R13 / R14 FIFO limit and ordering
      wr(I_CMD, 8'h01);
      rd(I_CAUSE, v);
      for (int k = 0; k < DEPTH - 1; k++) wr(I_FIFO, 8'(8'h40 + k));
      rd(I_FLAGS, v); chk("R13 count at limit", v, 8'(DEPTH - 1));
      wr(I_FIFO, 8'hEE);
      rd(I_FLAGS, v); chk("R13 overrun flag", v, 8'h40 | 8'(DEPTH - 1));
      rd(I_STAT, v);  chk("R13 gross error", v & 8'h40, 8'h40);
      rd(I_CAUSE, v);
      rd(I_STAT, v);  chk("R11 gross error cleared", v & 8'h40, 8'h00);
      for (int k = 0; k < DEPTH - 1; k++) begin
         rd(I_FIFO, b);
         chk("R14 fifo order", b, 8'(8'h40 + k));
      end
      rd(I_FIFO, v);  chk("R14 empty read", v, 8'h00);
      rd(I_FLAGS, v); chk("R13 overrun sticky", v, 8'h40);

      // R12 illegal leaves registers
      wr(I_CMD, 8'h2A);
      rd(I_FLAGS, v); chk("R12 illegal flag", v, 8'hC0);
      chk("R12 irq unchanged", {7'd0, irq}, 8'h00);
      rd(I_CMD, v);   chk("R12 command reg unchanged", v, 8'h01);
      wr(I_CMD, 8'h01);
      rd(I_FLAGS, v); chk("R3 flags cleared", v, 8'h00);
      rd(I_CAUSE, v);

      // R14 address low bits ignored
      @(negedge clk);
      addr = (ADDR_W'(I_CFG1) << SHIFT) | ADDR_W'(3);
      wdata = 8'h5A; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      addr = (ADDR_W'(I_CFG1) << SHIFT) | ADDR_W'(1);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk("R14 index shift", rdata, 8'h5A);

      // R8 chip reset from dirty state
      wr(I_LO, 8'h77);
      wr(I_CMD, 8'h80);
      wr(I_FIFO, 8'h11);
      wr(I_CMD, 8'h12);
      wr(I_CMD, 8'h02);
      chk("R8 irq", {7'd0, irq}, 8'h00);
      rd(I_CFG1, v);  chk("R8 cfg1", v, 8'h07);
      rd(I_FLAGS, v); chk("R8 flags", v, 8'h00);
      rd(I_LO, v);    chk("R8 count low", v, 8'h00);
      rd(I_STAT, v);  chk("R8 status", v, 8'h00);
      rd(I_CAUSE, v); chk("R8 cause", v, 8'h00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule